// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block sits between a simple request/response channel and the narrow control port of a PHY whose registers are not memory mapped. A request names a 16-bit PHY register address, carries write data when it is a write, and is accepted with a valid/ready handshake. The block then steps through a fixed series of control words, one strobe at a time. Each strobe is closed by waiting for the PHY acknowledge to rise, then waiting for it to fall. When the series ends, the block returns a one-cycle response with the read data and an error flag.

Every acknowledge wait is a bounded poll. The synchronized acknowledge is sampled once every `POLL_GAP` clock cycles, up to `MAX_POLLS` times. If the expected level never appears, the transaction is abandoned, the control word is cleared and the response reports an error. Only one transaction is in flight at a time. The acknowledge input passes through a two-flop synchronizer before any decision uses it.

Top module: `phy_ctl_master`

## Requirements
- R1: After reset, `req_ready` is 1, `phy_ctrl` is all zeros and `rsp_valid` is 0.
- R2: `phy_ctrl` bits 15:0 carry the address or data. Bit 16 is the capture-address strobe, bit 17 the capture-data strobe, bit 18 the write strobe and bit 19 the read strobe. No two strobes are ever set at once.
- R3: Every transaction opens with an address phase that drives these words in order: the address alone, then the address with bit 16 set, held until the acknowledge is seen high, then the address alone again, held until the acknowledge is seen low.
- R4: A write continues after the address phase with these words in order: the data alone; the data with bit 17 until the acknowledge is high; the data alone until it is low; bit 18 alone until it is high; the data alone until it is low; and finally all zeros.
- R5: A read continues after the address phase with bit 19 alone until the acknowledge (`phy_stat` bit 16) is high. It takes `phy_stat[15:0]` at that point as read data, then drives all zeros until the acknowledge is low.
- R6: An acknowledge wait samples the synchronized acknowledge every `POLL_GAP` cycles after the wait's control word appears. A slow acknowledge that arrives within `MAX_POLLS` samples still completes normally. If none of the `MAX_POLLS` samples matches, the timeout response appears exactly `MAX_POLLS*POLL_GAP` cycles after the wait's control word first appeared.
- R7: On a timeout, `phy_ctrl` goes to all zeros in the same cycle the response appears, with `rsp_err`=1 and `rsp_rdata`=0, and the block is ready for a new request.
- R8: `req_ready` is low from acceptance until the response. A request presented while busy is ignored. `rsp_valid` lasts one cycle, with `rsp_err`=0 for a completed transaction and `rsp_rdata` equal to the read data for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 16 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Acknowledge timeout occurred |
| phy_ctrl | output | 20 | Control word to the PHY |
| phy_stat | input | 17 | Status from the PHY: bit 16 acknowledge, bits 15:0 read data |

## Verification
The properties assume that the requester keeps its fields stable only until acceptance and issues nothing else that matters while busy. They also assume the PHY's read data is meaningful only while the read strobe is up and its acknowledge is seen high. The bench's PHY model raises its acknowledge only after seeing a strobe and drops it only after the strobes clear. It changes read data only with the read strobe, and it can be switched to an acknowledge stuck low or stuck high to reach the timeout paths. Requests are issued only when `req_ready` is seen high. During the busy test, the extra request is withdrawn before the first one finishes.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_ADDR_SET = 4'd1,
    ST_ADDR_CAP = 4'd2,
    ST_ADDR_REL = 4'd3,
    ST_DATA_SET = 4'd4,
    ST_DATA_CAP = 4'd5,
    ST_DATA_REL = 4'd6,
    ST_WR_STB   = 4'd7,
    ST_WR_REL   = 4'd8,
    ST_RD_STB   = 4'd9,
    ST_RD_REL   = 4'd10
  } hs_state_t;

  // strobe field, placed directly above the data field
  localparam logic [3:0] STB_NONE = 4'b0000;
  localparam logic [3:0] STB_CAPA = 4'b0001;
  localparam logic [3:0] STB_CAPD = 4'b0010;
  localparam logic [3:0] STB_WR   = 4'b0100;
  localparam logic [3:0] STB_RD   = 4'b1000;

  function automatic logic is_wait(hs_state_t s);
    case (s)
      ST_ADDR_CAP, ST_ADDR_REL, ST_DATA_CAP, ST_DATA_REL,
      ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL: is_wait = 1'b1;
      default: is_wait = 1'b0;
    endcase
  endfunction

  // acknowledge level each wait state is looking for
  function automatic logic wait_level(hs_state_t s);
    case (s)
      ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB: wait_level = 1'b1;
      default: wait_level = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/phy_ack_sync.sv
module phy_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b0;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/phy_ack_poller.sv
module phy_ack_poller #(
  parameter int POLL_GAP  = 200,
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic waiting,
  input  logic want_level,
  input  logic ack_s,
  output logic hit,
  output logic expire
);
  localparam int TW = (POLL_GAP  > 1) ? $clog2(POLL_GAP)  : 1;
  localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [TW-1:0] TMR_LAST  = TW'(POLL_GAP - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] polls_q;
  logic          sample;

  assign sample = waiting && (tmr_q == TMR_LAST);
  assign hit    = sample && (ack_s == want_level);
  assign expire = sample && (ack_s != want_level) && (polls_q == POLL_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q   <= '0;
      polls_q <= '0;
    end else if (arm) begin
      tmr_q   <= '0;
      polls_q <= '0;
    end else if (waiting) begin
      if (tmr_q == TMR_LAST) begin
        tmr_q   <= '0;
        polls_q <= polls_q + 1'b1;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_hs_fsm.sv
module phy_hs_fsm
  import phy_ctl_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          hit,
  input  logic          expire,
  input  logic [DW-1:0] rd_bus,
  output logic          arm,
  output logic          waiting,
  output logic          want_level,
  output logic [CW-1:0] ctrl_word,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err
);
  hs_state_t     state_q, nxt;
  logic [DW-1:0] addr_q, wdata_q, rd_q;
  logic          write_q;
  logic          ready_q;
  logic [CW-1:0] ctrl_q, word_d;
  logic          done, fail, take_rd;
  logic [DW-1:0] a_src, d_src;

  always_comb begin
    nxt     = state_q;
    done    = 1'b0;
    take_rd = 1'b0;
    case (state_q)
      ST_IDLE:     if (req_valid && ready_q) nxt = ST_ADDR_SET;
      ST_ADDR_SET: nxt = ST_ADDR_CAP;
      ST_ADDR_CAP: if (hit) nxt = ST_ADDR_REL;
      ST_ADDR_REL: if (hit) nxt = write_q ? ST_DATA_SET : ST_RD_STB;
      ST_DATA_SET: nxt = ST_DATA_CAP;
      ST_DATA_CAP: if (hit) nxt = ST_DATA_REL;
      ST_DATA_REL: if (hit) nxt = ST_WR_STB;
      ST_WR_STB:   if (hit) nxt = ST_WR_REL;
      ST_WR_REL:   if (hit) begin nxt = ST_IDLE; done = 1'b1; end
      ST_RD_STB:   if (hit) begin nxt = ST_RD_REL; take_rd = 1'b1; end
      ST_RD_REL:   if (hit) begin nxt = ST_IDLE; done = 1'b1; end
      default:     nxt = ST_IDLE;
    endcase
    fail = expire;
    if (expire) begin
      nxt     = ST_IDLE;
      done    = 1'b0;
      take_rd = 1'b0;
    end
  end

  assign a_src = (state_q == ST_IDLE) ? req_addr  : addr_q;
  assign d_src = (state_q == ST_IDLE) ? req_wdata : wdata_q;

  always_comb begin
    case (nxt)
      ST_ADDR_SET, ST_ADDR_REL:             word_d = {STB_NONE, a_src};
      ST_ADDR_CAP:                          word_d = {STB_CAPA, a_src};
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL:  word_d = {STB_NONE, d_src};
      ST_DATA_CAP:                          word_d = {STB_CAPD, d_src};
      ST_WR_STB:                            word_d = {STB_WR, {DW{1'b0}}};
      ST_RD_STB:                            word_d = {STB_RD, {DW{1'b0}}};
      default:                              word_d = '0;
    endcase
  end

  assign arm        = is_wait(nxt) && (nxt != state_q);
  assign waiting    = is_wait(state_q);
  assign want_level = wait_level(state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
      rd_q      <= '0;
      ready_q   <= 1'b1;
      ctrl_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      state_q <= nxt;
      ctrl_q  <= word_d;
      ready_q <= (nxt == ST_IDLE);
      if (state_q == ST_IDLE && req_valid && ready_q) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        write_q <= req_write;
      end
      if (take_rd) rd_q <= rd_bus;
      rsp_valid <= done || fail;
      rsp_err   <= fail;
      rsp_rdata <= (done && !write_q) ? rd_q : '0;
    end
  end

  assign req_ready = ready_q;
  assign ctrl_word = ctrl_q;
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master #(
  parameter int DW        = 16,
  parameter int POLL_GAP  = 200,
  parameter int MAX_POLLS = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CW = DW + 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [CW-1:0] phy_ctrl,
  input  logic [DW:0]   phy_stat
);
  logic ack_s, arm, waiting, want_level, hit, expire;

  phy_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (phy_stat[DW]),
    .q_sync  (ack_s)
  );

  phy_ack_poller #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .waiting    (waiting),
    .want_level (want_level),
    .ack_s      (ack_s),
    .hit        (hit),
    .expire     (expire)
  );

  phy_hs_fsm #(.DW(DW)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .hit        (hit),
    .expire     (expire),
    .rd_bus     (phy_stat[DW-1:0]),
    .arm        (arm),
    .waiting    (waiting),
    .want_level (want_level),
    .ctrl_word  (phy_ctrl),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err)
  );
endmodule

// File: rtl/phy_ctl_master_chk.sv
module phy_ctl_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_err,
  input logic [DW+3:0] phy_ctrl
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phy_ctrl[DW+3:DW])); // R2

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    ($fell(phy_ctrl[DW]) && !rsp_valid) |-> (phy_ctrl[DW-1:0] == $past(phy_ctrl[DW-1:0]))); // R3

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    ($fell(phy_ctrl[DW+1]) && !rsp_valid) |-> (phy_ctrl[DW-1:0] == $past(phy_ctrl[DW-1:0]))); // R4

  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(phy_ctrl[DW+2]) && !rsp_valid) |-> (phy_ctrl[DW+3:DW] == 4'b0000)); // R4

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(phy_ctrl[DW+3]) && !rsp_valid) |-> (phy_ctrl == '0)); // R5

  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0 && phy_ctrl == '0)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (phy_ctrl == '0)); // R1

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8

  AST_RSP_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready); // R8
endmodule

bind phy_ctl_master phy_ctl_master_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .phy_ctrl  (phy_ctrl)
);

// File: tb/phy_ctl_master_bench.sv
`timescale 1ns/1ps
module phy_ctl_master_bench;
  localparam int GAP = 4;
  localparam int NPOLL = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        rsp_err;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #2.5 clk = ~clk;

  phy_ctl_master #(.POLL_GAP(GAP), .MAX_POLLS(NPOLL)) u_phy_ctl_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // ---------------- PHY model ----------------
  int          lat = 2;
  int          mode = 0;  // 0 normal, 1 ack stuck low, 2 ack stuck high
  logic        ack_raw = 1'b0;
  int          dcnt = 0;
  logic [15:0] p_addr = '0, p_data = '0;
  logic [15:0] p_mem [256];
  logic        target;

  initial for (int i = 0; i < 256; i++) p_mem[i] = '0;

  always_comb begin
    if (mode == 1)      target = 1'b0;
    else if (mode == 2) target = ack_raw || (phy_ctrl[19:16] != 4'b0);
    else                target = (phy_ctrl[19:16] != 4'b0);
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (target != ack_raw) begin
      if (dcnt + 1 >= lat) begin ack_raw <= target; dcnt <= 0; end
      else dcnt <= dcnt + 1;
    end else dcnt <= 0;
    if (phy_ctrl[16] && !ack_raw) p_addr <= phy_ctrl[15:0];
    if (phy_ctrl[17] && !ack_raw) p_data <= phy_ctrl[15:0];
    if (phy_ctrl[18] && !ack_raw) p_mem[p_addr[7:0]] <= p_data;
  end

  assign phy_stat = {ack_raw, phy_ctrl[19] ? p_mem[p_addr[7:0]] : 16'h0000};

  // ---------------- scoreboard ----------------
  typedef struct { logic [19:0] w; string tag; } word_t;
  typedef struct { logic err; logic [15:0] data; int delta; string tag; } rsp_t;
  word_t wq[$];
  rsp_t  rq[$];
  logic [19:0] last_pushed = '0;
  logic [19:0] prev_ctrl = '0;
  int          t_last = 0;
  logic [15:0] shadow [256];

  initial for (int i = 0; i < 256; i++) shadow[i] = '0;

  function automatic void push_word(logic [19:0] w, string tag);
    word_t e;
    if (w != last_pushed) begin
      e.w = w; e.tag = tag;
      wq.push_back(e);
      last_pushed = w;
    end
  endfunction

  function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_valid) begin
        if (rq.size() == 0) check(1'b0, "R8 unexpected response", 32'(rsp_valid), 0);
        else begin
          rsp_t r;
          r = rq.pop_front();
          check(rsp_err == r.err, {r.tag, " err"}, 32'(rsp_err), 32'(r.err));
          check(rsp_rdata == r.data, {r.tag, " rdata"}, 32'(rsp_rdata), 32'(r.data));
          if (r.delta >= 0)
            check((cyc - t_last) == r.delta, "R6 timeout delay", 32'(cyc - t_last), 32'(r.delta));
        end
      end
      if (phy_ctrl != prev_ctrl) begin
        if (wq.size() == 0) check(1'b0, "R8 unexpected control word", 32'(phy_ctrl), 32'(prev_ctrl));
        else begin
          word_t e;
          e = wq.pop_front();
          check(phy_ctrl == e.w, e.tag, 32'(phy_ctrl), 32'(e.w));
        end
        prev_ctrl = phy_ctrl;
        t_last = cyc;
      end
    end
  end

  // ---------------- driver ----------------
  // kind: 0 normal, 1 timeout in address capture, 2 timeout in address release
  task automatic do_req(bit wr, logic [15:0] a, logic [15:0] d, int kind, bit busy_poke);
    rsp_t r;
    string t;
    t = wr ? "R4 write" : "R5 read";
    push_word({4'b0000, a}, "R3 addr set");
    push_word({4'b0001, a}, "R3 addr capture");
    if (kind == 1) begin
      push_word(20'h0, "R7 clear on timeout");
      r.err = 1'b1; r.data = '0; r.delta = NPOLL * GAP; r.tag = "R7 timeout";
    end else begin
      push_word({4'b0000, a}, "R3 addr release");
      if (kind == 2) begin
        push_word(20'h0, "R7 clear on timeout");
        r.err = 1'b1; r.data = '0; r.delta = NPOLL * GAP; r.tag = "R7 timeout";
      end else if (wr) begin
        push_word({4'b0000, d}, t);
        push_word({4'b0010, d}, t);
        push_word({4'b0000, d}, t);
        push_word({4'b0100, 16'h0}, t);
        push_word({4'b0000, d}, t);
        push_word(20'h0, t);
        shadow[a[7:0]] = d;
        r.err = 1'b0; r.data = '0; r.delta = -1; r.tag = "R8 write response";
      end else begin
        push_word({4'b1000, 16'h0}, t);
        push_word(20'h0, t);
        r.err = 1'b0; r.data = shadow[a[7:0]]; r.delta = -1; r.tag = "R5 read response";
      end
    end
    rq.push_back(r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    check(req_ready == 1'b0, "R8 busy after accept", 32'(req_ready), 0);
    if (busy_poke) begin
      req_write = 1'b1; req_addr = 16'h0066; req_wdata = 16'h9999;
      repeat (10) @(negedge clk);
      check(req_ready == 1'b0, "R8 still busy", 32'(req_ready), 0);
    end
    req_valid = 1'b0;
    while (rq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    check(wq.size() == 0, "R8 leftover control words", 32'(wq.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 1);
    check(phy_ctrl == 20'h0, "R1 ctrl after reset", 32'(phy_ctrl), 0);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 0);

    do_req(1'b1, 16'h0012, 16'hBEEF, 0, 1'b0);   // R4
    do_req(1'b0, 16'h0012, 16'h0000, 0, 1'b0);   // R5
    do_req(1'b1, 16'h00A5, 16'h00A5, 0, 1'b0);   // R2 address equal to data
    do_req(1'b0, 16'h0033, 16'h0000, 0, 1'b0);   // R5 unwritten register
    do_req(1'b1, 16'h0000, 16'h1234, 0, 1'b0);   // R3 zero address
    do_req(1'b0, 16'h0000, 16'h0000, 0, 1'b0);

    lat = 20;                                    // R6 slow ack still in time
    do_req(1'b1, 16'h0044, 16'h5A5A, 0, 1'b0);
    do_req(1'b0, 16'h0044, 16'h0000, 0, 1'b0);
    lat = 2;

    mode = 1;                                    // R6 R7 ack never rises
    do_req(1'b1, 16'h0077, 16'h4321, 1, 1'b0);
    mode = 0;
    repeat (10) @(negedge clk);
    do_req(1'b0, 16'h0077, 16'h0000, 0, 1'b0);   // R7 write did not land

    mode = 2;                                    // R7 ack never falls
    do_req(1'b0, 16'h0021, 16'h0000, 2, 1'b0);
    mode = 0;
    repeat (10) @(negedge clk);

    do_req(1'b1, 16'h0055, 16'hCAFE, 0, 1'b1);   // R8 request while busy ignored
    do_req(1'b0, 16'h0055, 16'h0000, 0, 1'b0);
    do_req(1'b0, 16'h0066, 16'h0000, 0, 1'b0);   // R8 poked write absent

    finish_run();
  end
endmodule